// File: doc/BRIEF.md
# Guest Exit Decision Filter

This block decides, one cycle after a guest event is presented, whether the guest must stop running and hand control back to the monitor. It also gives the reason for that exit. Five kinds of event are checked: a processor exception with its vector, an access to an I/O port, a read or a write of a model-specific register (MSR), an external interrupt, and a change of the guest's interrupt-enable flag. Filtering state is held locally. It consists of a 32-bit exception mask, a bit map over the full 16-bit port space, read and write bit maps over two MSR windows, and two control bits for interrupts.

The monitor writes the filter through a simple word-write port. Each write names a target with `cfg_sel`, a word index with `cfg_addr` and a 32-bit value. After that, the event inputs are driven every cycle as the guest runs. More than one event may arrive in the same cycle. In that case one fixed priority picks the single reason that is reported.

Top module: `vm_exit_filter`

## Requirements
- R1: Synchronous active-high reset clears the exit request, the exception mask and both interrupt control bits, so right after reset no exception and no interrupt causes an exit. Each decision appears on `exit_req`/`exit_reason` at the clock edge that follows the cycle in which the event is presented.
- R2: An exception with vector v (0..31) causes an exit with reason 0 exactly when bit v of the exception mask is set.
- R3: An I/O access to port p causes an exit with reason 30 exactly when the bit for p is set. Port bit 15 picks the half (`cfg_sel` 2 for the lower half, 3 for the upper half), p[14:5] picks the word and p[4:0] picks the bit within that word.
- R4: An MSR access to an address in 0x0000_0000..0x0000_1FFF looks up bit addr[12:0] in its own bit map for each direction. A read uses `cfg_sel` 4 and exits with reason 31. A write uses `cfg_sel` 6 and exits with reason 32. Word index is addr[12:5] and bit is addr[4:0].
- R5: An MSR access to an address in 0xC000_0000..0xC000_1FFF works the same way, using `cfg_sel` 5 for reads and 7 for writes.
- R6: An MSR access to an address outside both windows always exits, with reason 31 for a read and 32 for a write.
- R7: When control bit 0 (written with `cfg_sel` 1) is set, an external interrupt exits with reason 1, whatever the state of the guest interrupt-enable flag. When the bit is clear, an external interrupt does not exit.
- R8: When control bit 1 is set, a 0-to-1 change of `guest_if` exits with reason 7. The check compares against the flag's value in the previous cycle. Holding the flag at 1 and dropping it to 0 cause no exit.
- R9: When control bit 1 is clear, changes of `guest_if` in either direction cause no exit.
- R10: When several events would exit in the same cycle, exactly one reason is reported. The order is exception, then external interrupt, then interrupt window, then I/O, then MSR. An event that would not exit does not block a lower-priority one.
- R11: A configuration write takes effect only when `cfg_we` is high, updates only the target named by `cfg_sel`, and is seen by events from the next cycle on. `cfg_sel` 0 writes the exception mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 3 | Target: 0 exception mask, 1 control, 2/3 I/O halves, 4/5 MSR read low/high, 6/7 MSR write low/high |
| cfg_addr | input | 10 | Word index inside the target |
| cfg_wdata | input | 32 | Word to write |
| exc_valid | input | 1 | Exception event present |
| exc_vec | input | 5 | Exception vector |
| ext_intr | input | 1 | External interrupt event present |
| guest_if | input | 1 | Guest interrupt-enable flag (level) |
| io_valid | input | 1 | I/O access event present |
| io_port | input | 16 | Accessed port number |
| msr_valid | input | 1 | MSR access event present |
| msr_write | input | 1 | 1 = MSR write, 0 = MSR read |
| msr_addr | input | 32 | MSR address |
| exit_req | output | 1 | Exit requested (registered) |
| exit_reason | output | 6 | Reason code of the exit |

## Verification
The hardest case to reach is the full priority ladder. Every step needs a fresh rising edge of the interrupt-enable flag together with hits in all the other filters. To get there, the stimulus first lowers `guest_if` for a cycle and then raises it in the same cycle that all other events are driven, removing the top-priority source one step at a time. Full coverage of the storage comes from programming every word of every bit map with a computed pattern. Every port and every MSR in both windows and both directions is then swept back to back, so each cycle checks the previous lookup.

// File: rtl/vm_exit_pkg.sv
package vm_exit_pkg;

    localparam int unsigned MSR_IDX_W   = 13;
    localparam logic [31:0] MSR_HI_BASE = 32'hC000_0000;

    typedef enum logic [5:0] {
        RSN_EXC    = 6'd0,
        RSN_EXT    = 6'd1,
        RSN_WIN    = 6'd7,
        RSN_IO     = 6'd30,
        RSN_MSR_RD = 6'd31,
        RSN_MSR_WR = 6'd32
    } exit_reason_e;

    typedef enum logic [2:0] {
        CFG_EXC      = 3'd0,
        CFG_CTL      = 3'd1,
        CFG_IO_LO    = 3'd2,
        CFG_IO_HI    = 3'd3,
        CFG_MSR_RD_L = 3'd4,
        CFG_MSR_RD_H = 3'd5,
        CFG_MSR_WR_L = 3'd6,
        CFG_MSR_WR_H = 3'd7
    } cfg_sel_e;

    typedef struct packed {
        logic                 in_lo;
        logic                 in_hi;
        logic [MSR_IDX_W-1:0] idx;
    } msr_loc_t;

    function automatic msr_loc_t msr_locate(logic [31:0] addr);
        msr_loc_t loc;
        loc.in_lo = (addr[31:MSR_IDX_W] == '0);
        loc.in_hi = (addr[31:MSR_IDX_W] == MSR_HI_BASE[31:MSR_IDX_W]);
        loc.idx   = addr[MSR_IDX_W-1:0];
        return loc;
    endfunction

endpackage

// File: rtl/exit_bitmap_bank.sv
module exit_bitmap_bank #(
    parameter int unsigned IDX_W  = 15,
    parameter int unsigned WORD_W = 32
) (
    input  logic                            clk,
    input  logic                            we,
    input  logic [IDX_W-$clog2(WORD_W)-1:0] waddr,
    input  logic [WORD_W-1:0]               wdata,
    input  logic [IDX_W-1:0]                ridx,
    output logic                            rbit
);
    localparam int unsigned BIT_W = $clog2(WORD_W);
    localparam int unsigned AW    = IDX_W - BIT_W;
    localparam int unsigned DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rbit = mem[ridx[IDX_W-1:BIT_W]][ridx[BIT_W-1:0]];

endmodule

// File: rtl/exit_prio_sel.sv
module exit_prio_sel
    import vm_exit_pkg::*;
#(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] hit,
    input  exit_reason_e rsn [N],
    output logic         any,
    output exit_reason_e sel
);
    always_comb begin
        any = |hit;
        sel = RSN_EXC;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel = rsn[i];
            end
        end
    end
endmodule

// File: rtl/vm_exit_filter.sv
module vm_exit_filter
    import vm_exit_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned PORT_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_we,
    input  logic [2:0]                       cfg_sel,
    input  logic [PORT_W-2-$clog2(WORD_W):0] cfg_addr,
    input  logic [WORD_W-1:0]                cfg_wdata,
    input  logic                             exc_valid,
    input  logic [$clog2(WORD_W)-1:0]        exc_vec,
    input  logic                             ext_intr,
    input  logic                             guest_if,
    input  logic                             io_valid,
    input  logic [PORT_W-1:0]                io_port,
    input  logic                             msr_valid,
    input  logic                             msr_write,
    input  logic [31:0]                      msr_addr,
    output logic                             exit_req,
    output logic [5:0]                       exit_reason
);
    localparam int unsigned BIT_W   = $clog2(WORD_W);
    localparam int unsigned HALF_W  = PORT_W - 1;
    localparam int unsigned MSR_AW  = MSR_IDX_W - BIT_W;
    localparam int unsigned N_SRC   = 5;

    // configuration state
    logic [WORD_W-1:0] exc_map_q;
    logic              ctl_ext_q;
    logic              ctl_win_q;
    logic              if_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_map_q <= '0;
            ctl_ext_q <= 1'b0;
            ctl_win_q <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel == CFG_EXC) begin
                exc_map_q <= cfg_wdata;
            end
            if (cfg_sel == CFG_CTL) begin
                ctl_ext_q <= cfg_wdata[0];
                ctl_win_q <= cfg_wdata[1];
            end
        end
    end

    // registered copy of the interrupt-enable flag; reset high so a
    // flag already at 1 when reset is released is not taken as a rise
    always_ff @(posedge clk) begin
        if (rst) begin
            if_q <= 1'b1;
        end else begin
            if_q <= guest_if;
        end
    end

    // I/O port map: two halves picked by the top port bit
    logic [1:0] io_half_bit;

    for (genvar h = 0; h < 2; h++) begin : g_io
        exit_bitmap_bank #(
            .IDX_W (HALF_W),
            .WORD_W(WORD_W)
        ) u_bank (
            .clk  (clk),
            .we   (cfg_we && (cfg_sel == 3'(32'(CFG_IO_LO) + h))),
            .waddr(cfg_addr),
            .wdata(cfg_wdata),
            .ridx (io_port[HALF_W-1:0]),
            .rbit (io_half_bit[h])
        );
    end

    // MSR maps: index [2*dir + range], dir 0 read / 1 write, range 0 low / 1 high
    msr_loc_t   loc;
    logic [3:0] msr_bits;

    assign loc = msr_locate(msr_addr);

    for (genvar d = 0; d < 2; d++) begin : g_dir
        for (genvar r = 0; r < 2; r++) begin : g_rng
            exit_bitmap_bank #(
                .IDX_W (MSR_IDX_W),
                .WORD_W(WORD_W)
            ) u_bank (
                .clk  (clk),
                .we   (cfg_we && (cfg_sel == 3'(32'(CFG_MSR_RD_L) + 2 * d + r))),
                .waddr(cfg_addr[MSR_AW-1:0]),
                .wdata(cfg_wdata),
                .ridx (loc.idx),
                .rbit (msr_bits[2*d+r])
            );
        end
    end

    // per-source decisions
    logic         exc_hit, ext_hit, win_hit, io_hit, msr_hit, msr_map_bit;
    logic [N_SRC-1:0] hits;
    exit_reason_e rsn_tbl [N_SRC];
    exit_reason_e pick;
    logic         pick_any;

    always_comb begin
        msr_map_bit = msr_bits[{msr_write, loc.in_hi}];
        exc_hit = exc_valid && exc_map_q[exc_vec];
        ext_hit = ext_intr && ctl_ext_q;
        win_hit = ctl_win_q && guest_if && !if_q;
        io_hit  = io_valid && io_half_bit[io_port[PORT_W-1]];
        msr_hit = msr_valid && ((loc.in_lo || loc.in_hi) ? msr_map_bit : 1'b1);
        hits    = {msr_hit, io_hit, win_hit, ext_hit, exc_hit};
        rsn_tbl[0] = RSN_EXC;
        rsn_tbl[1] = RSN_EXT;
        rsn_tbl[2] = RSN_WIN;
        rsn_tbl[3] = RSN_IO;
        rsn_tbl[4] = msr_write ? RSN_MSR_WR : RSN_MSR_RD;
    end

    exit_prio_sel #(.N(N_SRC)) u_prio (
        .hit(hits),
        .rsn(rsn_tbl),
        .any(pick_any),
        .sel(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exit_req    <= 1'b0;
            exit_reason <= RSN_EXC;
        end else begin
            exit_req    <= pick_any;
            exit_reason <= pick_any ? pick : RSN_EXC;
        end
    end

endmodule

// File: rtl/vm_exit_filter_chk.sv
module vm_exit_filter_chk
    import vm_exit_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      exc_valid,
    input logic [$clog2(WORD_W)-1:0] exc_vec,
    input logic                      ext_intr,
    input logic                      guest_if,
    input logic                      io_valid,
    input logic                      msr_valid,
    input logic                      exit_req,
    input logic [5:0]                exit_reason,
    input logic [WORD_W-1:0]         exc_map,
    input logic                      ctl_ext,
    input logic                      ctl_win
);
    logic exc_fire, ext_fire;
    assign exc_fire = exc_valid && exc_map[exc_vec];
    assign ext_fire = ext_intr && ctl_ext;

    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !exit_req);

    // R2
    a_r2_exc_exit: assert property (@(posedge clk) disable iff (rst)
        exc_fire |=> (exit_req && exit_reason == RSN_EXC));

    // R7, R10
    a_r7_ext_exit: assert property (@(posedge clk) disable iff (rst)
        (ext_fire && !exc_fire) |=> (exit_req && exit_reason == RSN_EXT));

    // R8, R10
    a_r8_window_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ctl_win && guest_if && !$past(guest_if) && !exc_fire && !ext_fire)
        |=> (exit_req && exit_reason == RSN_WIN));

    // R9
    a_r9_quiet_no_exit: assert property (@(posedge clk) disable iff (rst)
        (!exc_valid && !ext_intr && !io_valid && !msr_valid && !ctl_win) |=> !exit_req);

    // R10
    a_r10_legal_reason: assert property (@(posedge clk) disable iff (rst)
        exit_req |-> (exit_reason inside {RSN_EXC, RSN_EXT, RSN_WIN, RSN_IO,
                                          RSN_MSR_RD, RSN_MSR_WR}));

endmodule

bind vm_exit_filter vm_exit_filter_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .exc_valid  (exc_valid),
    .exc_vec    (exc_vec),
    .ext_intr   (ext_intr),
    .guest_if   (guest_if),
    .io_valid   (io_valid),
    .msr_valid  (msr_valid),
    .exit_req   (exit_req),
    .exit_reason(exit_reason),
    .exc_map    (exc_map_q),
    .ctl_ext    (ctl_ext_q),
    .ctl_win    (ctl_win_q)
);

// File: tb/vm_exit_filter_tb.sv
module vm_exit_filter_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [9:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        exc_valid;
    logic [4:0]  exc_vec;
    logic        ext_intr;
    logic        guest_if;
    logic        io_valid;
    logic [15:0] io_port;
    logic        msr_valid;
    logic        msr_write;
    logic [31:0] msr_addr;
    logic        exit_req;
    logic [5:0]  exit_reason;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] EXC_PAT = 32'hA5C3_1E69;

    always #4 clk = ~clk;

    vm_exit_filter u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .exc_valid(exc_valid), .exc_vec(exc_vec), .ext_intr(ext_intr), .guest_if(guest_if),
        .io_valid(io_valid), .io_port(io_port),
        .msr_valid(msr_valid), .msr_write(msr_write), .msr_addr(msr_addr),
        .exit_req(exit_req), .exit_reason(exit_reason)
    );

    function automatic logic pat(int sel, int idx);
        return (((idx & 15) + ((idx >> 6) & 15) + sel) % 3) == 0;
    endfunction

    function automatic logic [31:0] pword(int sel, int w);
        logic [31:0] r;
        for (int b = 0; b < 32; b++) r[b] = pat(sel, w * 32 + b);
        return r;
    endfunction

    task automatic chk(string tag, logic exp_req, int exp_rsn);
        n_chk++;
        if (exit_req !== exp_req || (exp_req && exit_reason !== 6'(exp_rsn))) begin
            n_fail++;
            $display("FAIL %s: got req=%0b reason=%0d, expected req=%0b reason=%0d",
                     tag, exit_req, exit_reason, exp_req, exp_rsn);
        end
    endtask

    task automatic idle_events();
        exc_valid = 1'b0; exc_vec = '0; ext_intr = 1'b0;
        io_valid = 1'b0; io_port = '0;
        msr_valid = 1'b0; msr_write = 1'b0; msr_addr = '0;
    endtask

    task automatic sample(string tag, logic exp_req, int exp_rsn);
        @(negedge clk);
        chk(tag, exp_req, exp_rsn);
        idle_events();
    endtask

    task automatic cfg1(int sel, int addr, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_addr = 10'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fill(int sel, int words);
        for (int w = 0; w < words; w++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_addr = 10'(w); cfg_wdata = pword(sel, w);
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prio(string tag, logic e, int v, logic x, logic w, logic i,
                        logic m, logic mw, logic exp_req, int exp_rsn);
        @(negedge clk);
        idle_events(); guest_if = 1'b0;
        @(negedge clk);
        exc_valid = e; exc_vec = 5'(v); ext_intr = x; guest_if = w;
        io_valid = i; io_port = 16'd1;
        msr_valid = m; msr_write = mw; msr_addr = 32'h0000_2000;
        sample(tag, exp_req, exp_rsn);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_addr = '0; cfg_wdata = '0;
        guest_if = 1'b0;
        idle_events();
        repeat (3) @(negedge clk);
        chk("R1 during reset", 1'b0, 0);
        rst = 1'b0;

        // R1: nothing exits right after reset
        for (int v = 0; v < 32; v++) begin
            @(negedge clk); exc_valid = 1'b1; exc_vec = 5'(v);
            sample("R1 exception after reset", 1'b0, 0);
        end
        @(negedge clk); ext_intr = 1'b1;
        sample("R1 interrupt after reset", 1'b0, 0);

        // R11: strobe low leaves the exception mask untouched
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 3'd0; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); exc_valid = 1'b1; exc_vec = 5'd5;
        sample("R11 write without strobe", 1'b0, 0);

        // R2 sweep
        cfg1(0, 0, EXC_PAT);
        for (int v = 0; v < 32; v++) begin
            @(negedge clk); exc_valid = 1'b1; exc_vec = 5'(v);
            sample("R2 exception mask", EXC_PAT[v], 0);
        end

        // R11: control write does not disturb exception mask
        cfg1(1, 0, 32'h0);
        @(negedge clk); exc_valid = 1'b1; exc_vec = 5'd0;
        sample("R11 other target", 1'b1, 0);

        // R3: fill both halves and sweep every port back to back
        fill(2, 1024);
        fill(3, 1024);
        for (int p = 0; p < 65536; p++) begin
            @(negedge clk);
            if (p > 0) chk("R3 io port", pat(2 + ((p - 1) >> 15), (p - 1) & 16'h7FFF), 30);
            io_valid = 1'b1; io_port = 16'(p);
        end
        @(negedge clk);
        chk("R3 io port 65535", pat(3, 16'h7FFF), 30);
        idle_events();

        // R4 / R5: four maps, every index, back to back
        fill(4, 256); fill(5, 256); fill(6, 256); fill(7, 256);
        for (int d = 0; d < 2; d++) begin
            for (int r = 0; r < 2; r++) begin
                for (int i = 0; i <= 8192; i++) begin
                    @(negedge clk);
                    if (i > 0) chk(r ? "R5 msr high window" : "R4 msr low window",
                                   pat(4 + 2 * d + r, i - 1), d ? 32 : 31);
                    if (i < 8192) begin
                        msr_valid = 1'b1; msr_write = d[0];
                        msr_addr = (r ? 32'hC000_0000 : 32'h0) + 32'(i);
                    end else begin
                        idle_events();
                    end
                end
            end
        end

        // R6: outside both windows
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                msr_valid = 1'b1; msr_write = d[0];
                case (k)
                    0: msr_addr = 32'h0000_2000;
                    1: msr_addr = 32'hBFFF_FFFF;
                    2: msr_addr = 32'hC000_2000;
                    default: msr_addr = 32'hFFFF_FFFF;
                endcase
                sample("R6 msr outside windows", 1'b1, d ? 32 : 31);
            end
        end

        // R7 / R9 with controls clear
        @(negedge clk); ext_intr = 1'b1;
        sample("R7 interrupt control clear", 1'b0, 0);
        @(negedge clk); guest_if = 1'b1;
        sample("R9 enable rise, window off", 1'b0, 0);
        @(negedge clk); guest_if = 1'b0;
        sample("R9 enable fall, window off", 1'b0, 0);

        // R7 with external control set, guest masked
        cfg1(1, 0, 32'h1);
        @(negedge clk); ext_intr = 1'b1; guest_if = 1'b0;
        sample("R7 interrupt while masked", 1'b1, 1);
        @(negedge clk); guest_if = 1'b1;
        sample("R9 rise, only ext control", 1'b0, 0);

        // R8 window control
        cfg1(1, 0, 32'h2);
        @(negedge clk); guest_if = 1'b0;
        sample("R8 fall", 1'b0, 0);
        @(negedge clk); guest_if = 1'b1;
        sample("R8 rise", 1'b1, 7);
        sample("R8 held high", 1'b0, 0);
        @(negedge clk); ext_intr = 1'b1;
        sample("R7 ext control clear", 1'b0, 0);

        // R10 priority ladder
        cfg1(1, 0, 32'h3);
        prio("R10 all sources", 1, 0, 1, 1, 1, 1, 0, 1'b1, 0);
        prio("R10 no exception", 0, 0, 1, 1, 1, 1, 0, 1'b1, 1);
        prio("R10 window over io", 0, 0, 0, 1, 1, 1, 0, 1'b1, 7);
        prio("R10 io over msr", 0, 0, 0, 0, 1, 1, 0, 1'b1, 30);
        prio("R10 msr write alone", 0, 0, 0, 0, 0, 1, 1, 1'b1, 32);
        prio("R10 masked exception skipped", 1, 1, 0, 0, 1, 0, 0, 1'b1, 30);
        prio("R10 masked exception alone", 1, 1, 0, 0, 0, 0, 0, 1'b0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule